// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order pipeline, where each of its two ALU operands should come from. An operand can be taken from the value read out of the register file, from the result now in the writeback stage, or from the ALU result now in the memory stage. The unit compares the two execute-stage source register numbers against the destination numbers of the two older instructions. It uses only the matches whose write flag is set and whose destination is not register 0.

Each operand has a 2-bit select code, and a matching 3-input multiplexer applies that code to produce the operand value. The logic has no clock and no state. Both outputs follow the inputs within the same cycle.

The memory-stage instruction is the more recent of the two older instructions. When both older stages write the same register, the memory-stage result wins, so the newest value of a register that was written twice in a row reaches the ALU.

Top module: `fwd_unit`

## Requirements
- R1: A select takes code 2 (memory-stage result) when the memory-stage write flag is 1, the memory-stage destination is nonzero, and that destination equals the operand's source number. Operand A uses the first source number and operand B uses the second.
- R2: A select takes code 1 (writeback-stage result) when the writeback-stage write flag is 1, its destination is nonzero and equal to the operand's source number, and the memory stage does not meet the R1 condition for that operand.
- R3: When the memory and writeback stages both meet their conditions for the same operand, the select is 2.
- R4: A destination number of 0 never causes forwarding, whatever the write flag is.
- R5: A stage whose write flag is 0 never causes forwarding, whatever its destination number is.
- R6: When neither stage matches, a select is 0 (register-file value). This includes the all-zero input state.
- R7: Each operand output equals the register-file value for code 0, the writeback result for code 1 and the memory result for code 2.
- R8: Operand A is compared only with the first source number and operand B only with the second. The two selects are computed independently, and neither ever takes code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b_idx | input | 5 | Second source register number of the execute-stage instruction |
| mem_dst_idx | input | 5 | Destination register number of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst_idx | input | 5 | Destination register number of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| rf_a_data | input | 32 | Register-file value for operand A |
| rf_b_data | input | 32 | Register-file value for operand B |
| mem_result | input | 32 | ALU result held in the memory stage |
| wb_result | input | 32 | Result held in the writeback stage |
| sel_a | output | 2 | Select code for operand A (0 register file, 1 writeback, 2 memory) |
| sel_b | output | 2 | Select code for operand B (same encoding) |
| op_a | output | 32 | Forwarded operand A |
| op_b | output | 32 | Forwarded operand B |

## Verification
Every result is combinational, so both select codes and both operand values are due in the same cycle in which a stimulus is applied, with no register delay. The bench drives each new stimulus just after a rising clock edge and samples all four outputs at the following falling edge, which leaves half a period for settling and keeps the samples away from the edge. The sweep covers every combination of register numbers 0 to 3 for the two sources and two destinations, together with all four write-flag combinations. A second pass uses high register numbers. Expected values come from the requirement rules, evaluated arithmetically in the bench.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF   = 2'd0,
    FWD_WB   = 2'd1,
    FWD_MEM  = 2'd2,
    FWD_RSVD = 2'd3
  } fwd_sel_e;

  localparam int NUM_OPS = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_idx,
  input  logic [REG_W-1:0] dst_idx,
  input  logic             wr_en,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = wr_en && (dst_idx != ZERO_REG) && (dst_idx == src_idx);
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  logic     mem_hit,
  input  logic     wb_hit,
  output fwd_sel_e sel
);
  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] op_data
);
  always_comb begin
    case (sel)
      FWD_WB:  op_data = wb_data;
      FWD_MEM: op_data = mem_data;
      default: op_data = rf_data;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_src_a_idx,
  input  logic [REG_W-1:0]  ex_src_b_idx,
  input  logic [REG_W-1:0]  mem_dst_idx,
  input  logic              mem_wr_en,
  input  logic [REG_W-1:0]  wb_dst_idx,
  input  logic              wb_wr_en,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [DATA_W-1:0] mem_result,
  input  logic [DATA_W-1:0] wb_result,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  logic [REG_W-1:0]  src_idx [NUM_OPS];
  logic [DATA_W-1:0] rf_data [NUM_OPS];
  logic [DATA_W-1:0] op_data [NUM_OPS];
  fwd_sel_e          sel     [NUM_OPS];
  logic              mem_hit [NUM_OPS];
  logic              wb_hit  [NUM_OPS];

  assign src_idx[0] = ex_src_a_idx;
  assign src_idx[1] = ex_src_b_idx;
  assign rf_data[0] = rf_a_data;
  assign rf_data[1] = rf_b_data;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    fwd_match #(.REG_W(REG_W)) mem_cmp_i (
      .src_idx (src_idx[op]),
      .dst_idx (mem_dst_idx),
      .wr_en   (mem_wr_en),
      .hit     (mem_hit[op])
    );

    fwd_match #(.REG_W(REG_W)) wb_cmp_i (
      .src_idx (src_idx[op]),
      .dst_idx (wb_dst_idx),
      .wr_en   (wb_wr_en),
      .hit     (wb_hit[op])
    );

    fwd_select sel_i (
      .mem_hit (mem_hit[op]),
      .wb_hit  (wb_hit[op]),
      .sel     (sel[op])
    );

    fwd_mux #(.DATA_W(DATA_W)) mux_i (
      .sel      (sel[op]),
      .rf_data  (rf_data[op]),
      .wb_data  (wb_result),
      .mem_data (mem_result),
      .op_data  (op_data[op])
    );
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];
  assign op_a  = op_data[0];
  assign op_b  = op_data[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  ex_src_a_idx,
  input logic [REG_W-1:0]  ex_src_b_idx,
  input logic [REG_W-1:0]  mem_dst_idx,
  input logic              mem_wr_en,
  input logic [REG_W-1:0]  wb_dst_idx,
  input logic              wb_wr_en,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [DATA_W-1:0] rf_b_data,
  input logic [DATA_W-1:0] mem_result,
  input logic [DATA_W-1:0] wb_result,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b
);
  logic known;
  logic mem_a, mem_b, wb_a, wb_b;

  always_comb begin
    known = !$isunknown({ex_src_a_idx, ex_src_b_idx, mem_dst_idx, mem_wr_en,
                         wb_dst_idx, wb_wr_en, sel_a, sel_b});
    mem_a = mem_wr_en && (|mem_dst_idx) && (mem_dst_idx == ex_src_a_idx);
    mem_b = mem_wr_en && (|mem_dst_idx) && (mem_dst_idx == ex_src_b_idx);
    wb_a  = wb_wr_en  && (|wb_dst_idx)  && (wb_dst_idx  == ex_src_a_idx);
    wb_b  = wb_wr_en  && (|wb_dst_idx)  && (wb_dst_idx  == ex_src_b_idx);
  end

  always_comb begin
    if (known) begin
      if (mem_a) assert_mem_fwd_a_R1: assert (sel_a == 2'd2);
      if (mem_b) assert_mem_fwd_b_R1: assert (sel_b == 2'd2);
      if (wb_a && !mem_a) assert_wb_fwd_a_R2: assert (sel_a == 2'd1);
      if (wb_b && !mem_b) assert_wb_fwd_b_R2: assert (sel_b == 2'd1);
      if (!mem_a && !wb_a) assert_no_fwd_a_R6: assert (sel_a == 2'd0);
      if (!mem_b && !wb_b) assert_no_fwd_b_R6: assert (sel_b == 2'd0);
      assert_no_code3_R8: assert (sel_a != 2'd3 && sel_b != 2'd3);
      if (sel_a == 2'd0) assert_op_a_rf_R7:  assert (op_a == rf_a_data);
      if (sel_a == 2'd1) assert_op_a_wb_R7:  assert (op_a == wb_result);
      if (sel_a == 2'd2) assert_op_a_mem_R7: assert (op_a == mem_result);
      if (sel_b == 2'd0) assert_op_b_rf_R7:  assert (op_b == rf_b_data);
      if (sel_b == 2'd1) assert_op_b_wb_R7:  assert (op_b == wb_result);
      if (sel_b == 2'd2) assert_op_b_mem_R7: assert (op_b == mem_result);
    end
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .ex_src_a_idx (ex_src_a_idx),
  .ex_src_b_idx (ex_src_b_idx),
  .mem_dst_idx  (mem_dst_idx),
  .mem_wr_en    (mem_wr_en),
  .wb_dst_idx   (wb_dst_idx),
  .wb_wr_en     (wb_wr_en),
  .rf_a_data    (rf_a_data),
  .rf_b_data    (rf_b_data),
  .mem_result   (mem_result),
  .wb_result    (wb_result),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .op_a         (op_a),
  .op_b         (op_b)
);

// File: tb/fwd_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_unit_tb_top;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic clk;
  logic rst_n;
  logic [REG_W-1:0]  ex_src_a_idx, ex_src_b_idx, mem_dst_idx, wb_dst_idx;
  logic              mem_wr_en, wb_wr_en;
  logic [DATA_W-1:0] rf_a_data, rf_b_data, mem_result, wb_result;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] op_a, op_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) dut_i (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .mem_dst_idx  (mem_dst_idx),
    .mem_wr_en    (mem_wr_en),
    .wb_dst_idx   (wb_dst_idx),
    .wb_wr_en     (wb_wr_en),
    .rf_a_data    (rf_a_data),
    .rf_b_data    (rf_b_data),
    .mem_result   (mem_result),
    .wb_result    (wb_result),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .op_a         (op_a),
    .op_b         (op_b)
  );

  function automatic int exp_sel(int src, int mw, int md, int ww, int wd);
    if (mw != 0 && md != 0 && md == src) return 2;
    if (ww != 0 && wd != 0 && wd == src) return 1;
    return 0;
  endfunction

  function automatic string tag_of(int src, int mw, int md, int ww, int wd);
    bit mh = (mw != 0 && md != 0 && md == src);
    bit wh = (ww != 0 && wd != 0 && wd == src);
    if (mh && wh) return "R3";
    if (mh) return "R1";
    if (wh) return "R2";
    if ((md == src && md == 0 && mw != 0) || (wd == src && wd == 0 && ww != 0)) return "R4";
    if ((md == src && mw == 0) || (wd == src && ww == 0)) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(int sa, int sb, int mw, int md, int ww, int wd, int seed);
    @(posedge clk);
    #0.5;
    ex_src_a_idx = REG_W'(sa);
    ex_src_b_idx = REG_W'(sb);
    mem_wr_en    = mw[0];
    mem_dst_idx  = REG_W'(md);
    wb_wr_en     = ww[0];
    wb_dst_idx   = REG_W'(wd);
    rf_a_data    = 32'hA000_0000 + 32'(seed);
    rf_b_data    = 32'hB000_0000 + 32'(seed);
    mem_result   = 32'hC000_0000 + 32'(seed);
    wb_result    = 32'hD000_0000 + 32'(seed);
    @(negedge clk);
    begin
      int ea = exp_sel(sa, mw, md, ww, wd);
      int eb = exp_sel(sb, mw, md, ww, wd);
      logic [DATA_W-1:0] eoa = (ea == 2) ? mem_result : (ea == 1) ? wb_result : rf_a_data;
      logic [DATA_W-1:0] eob = (eb == 2) ? mem_result : (eb == 1) ? wb_result : rf_b_data;
      check(tag_of(sa, mw, md, ww, wd), "sel_a", longint'(sel_a), longint'(ea));
      check(tag_of(sb, mw, md, ww, wd), "sel_b", longint'(sel_b), longint'(eb));
      check("R7", "op_a", longint'(op_a), longint'(eoa));
      check("R7", "op_b", longint'(op_b), longint'(eob));
      check("R8", "no code 3", longint'(sel_a == 2'd3 || sel_b == 2'd3), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ex_src_a_idx = '0; ex_src_b_idx = '0; mem_dst_idx = '0; wb_dst_idx = '0;
    mem_wr_en = 1'b0; wb_wr_en = 1'b0;
    rf_a_data = 32'h1234_5678; rf_b_data = 32'h8765_4321;
    mem_result = 32'hCAFE_0000; wb_result = 32'hBEEF_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: idle all-zero state selects the register file
    check("R6", "idle sel_a", longint'(sel_a), 0);
    check("R6", "idle sel_b", longint'(sel_b), 0);
    check("R6", "idle op_a", longint'(op_a), longint'(32'h1234_5678));
    rst_n = 1'b1;

    // Exhaustive sweep of register numbers 0..3 and write flags
    for (int sa = 0; sa < 4; sa++)
      for (int sb = 0; sb < 4; sb++)
        for (int md = 0; md < 4; md++)
          for (int wd = 0; wd < 4; wd++)
            for (int fl = 0; fl < 4; fl++)
              apply(sa, sb, fl & 1, md, (fl >> 1) & 1, wd,
                    (((sa * 4 + sb) * 4 + md) * 4 + wd) * 4 + fl);

    // High register numbers, both operands from different or same stages (R8)
    for (int r = 28; r < 32; r++)
      for (int fl = 0; fl < 4; fl++) begin
        apply(r, 31 - r + 28, fl & 1, r, (fl >> 1) & 1, 31 - r + 28, 2000 + r * 4 + fl);
        apply(r, r, fl & 1, r, (fl >> 1) & 1, r, 3000 + r * 4 + fl);
      end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule